// File: doc/BRIEF.md
# Low-Voltage Reset Filter Controller

This block is the digital decision stage behind a supply-voltage monitor. Two analog comparators feed it. One reports that the supply has dropped under the falling trip level. The other reports that the supply has climbed over a separate, higher rising trip level. Both comparator signals pass through a clock-domain synchronizer before any logic uses them.

A run counter measures how many consecutive CPU clock cycles the supply has stayed low. A reset is requested only after a sustained dip, so short spikes are filtered out. Release is asymmetric: a single cycle above the rising level ends the reset. Configuration enables arrive as plain input levels:
- a power enable, which gates all monitoring;
- a reset enable, which gates the request;
- a stop-mode enable, which keeps monitoring alive while the device is stopped.

The block produces three outputs: a raw low-supply status flag, an internal reset request and an active-low drive for the external reset pin.

Top module: `lvr_filter_ctrl`

## Requirements
- R1: While and right after the asynchronous reset, the status flag is 0, the reset request is 0, the reset pin drive is 1 and the run count is zero. Monitoring is active from the first clock after reset, with no extra set-up.
- R2: The status flag equals the below-falling comparator input delayed by the two synchronizer flops. It follows that input whatever the three enables and the stop indicator are.
- R3: With monitoring active and reset enabled, the reset request rises at the clock edge that ends the ninth consecutive cycle in which the synchronized below-falling indication is 1.
- R4: Any synchronized cycle in which the below-falling indication is 0 returns the run count to zero. A dip of eight cycles, a one-cycle gap and another eight cycles therefore produces no reset.
- R5: Once the request is asserted, it stays asserted until the synchronized above-rising indication is 1. One such cycle clears the request at the next edge.
- R6: With the power enable at 0, the run count is held at zero and no request is made. Dropping the power enable while a request is active clears the request at the next edge.
- R7: With the reset enable at 0, no request is made. Dropping it while a request is active clears the request at the next edge. The run count keeps counting in either case.
- R8: With the stop indicator at 1 and the stop-mode enable at 0, monitoring is suspended: the count is cleared and no request is made. With the stop-mode enable at 1, monitoring continues in stop mode.
- R9: The reset pin drive is 0 in exactly the cycles in which the reset request is 1.
- R10: The 4-bit run count saturates at 15 and does not wrap. After a low supply of 30 or more cycles with the reset enable at 0, setting the reset enable raises the request at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_pwr_en | input | 1 | Monitoring power enable |
| cfg_rst_en | input | 1 | Low-voltage reset enable |
| cfg_stop_en | input | 1 | Keep monitoring while stopped |
| stop_mode | input | 1 | Device is in stop mode |
| cmp_below_fall | input | 1 | Comparator: supply below falling trip level |
| cmp_above_rise | input | 1 | Comparator: supply above rising trip level |
| low_flag | output | 1 | Status flag, synchronized low-supply indication |
| lv_reset_req | output | 1 | Internal low-voltage reset request |
| ext_rst_n | output | 1 | Active-low drive for the external reset pin |

## Verification
The bench probes the count boundary with dips of exactly eight cycles separated by a single high cycle. A counter that failed to restart on a gap, or one that tripped a cycle early, would raise a reset there. It also holds a dip for longer than nine cycles and confirms that the reset rises on precisely the ninth synchronized cycle; an off-by-one compare or a missing synchronizer stage shifts that edge.

A one-cycle above-rise pulse must release the reset, which catches designs that filter the release as well. The bench then holds the supply low for more than sixteen cycles with the reset disabled and enables it afterwards. A wrapping counter would then wait before tripping instead of tripping at once.

Further scenarios cover power-off, stop mode with and without the stop enable, and disabling during an active reset. In these, a design that ignored a gate would assert or hold the reset when it should not.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
   typedef enum logic [0:0] {
      ST_WATCH = 1'b0,
      ST_HOLD  = 1'b1
   } lvr_state_e;
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lvr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/lvr_run_counter.sv
module lvr_run_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lvr_run_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (clear)                cnt_next = '0;
      else if (!step)           cnt_next = cnt;
      else if (cnt == CNT_MAX)  cnt_next = CNT_MAX;
      else                      cnt_next = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end
endmodule

// File: rtl/lvr_hold_fsm.sv
module lvr_hold_fsm
   import lvr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic release_now,
   output logic hold
);
   lvr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_WATCH: if (trip)        state_d = ST_HOLD;
         ST_HOLD:  if (release_now) state_d = ST_WATCH;
         default:                   state_d = ST_WATCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WATCH;
      else        state_q <= state_d;
   end

   assign hold = (state_q == ST_HOLD);
endmodule

// File: rtl/lvr_filter_ctrl.sv
module lvr_filter_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4,
   parameter int TRIP_COUNT  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_pwr_en,
   input  logic cfg_rst_en,
   input  logic cfg_stop_en,
   input  logic stop_mode,
   input  logic cmp_below_fall,
   input  logic cmp_above_rise,
   output logic low_flag,
   output logic lv_reset_req,
   output logic ext_rst_n
);
   localparam logic [CNT_W-1:0] TRIP_AT = CNT_W'(TRIP_COUNT);

   generate
      if (TRIP_COUNT < 1 || TRIP_COUNT >= (1 << CNT_W)) begin : g_bad_trip
         $error("lvr_filter_ctrl: TRIP_COUNT must fit below the counter maximum");
      end
   endgenerate

   logic [1:0]       cmp_sync;
   logic             below_s;
   logic             above_s;
   logic             active;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_cnt_next;
   logic             trip;
   logic             release_now;

   lvr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cmp_above_rise, cmp_below_fall}),
      .d_out (cmp_sync)
   );

   assign below_s = cmp_sync[0];
   assign above_s = cmp_sync[1];
   assign active  = cfg_pwr_en && (!stop_mode || cfg_stop_en);

   lvr_run_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!active || !below_s),
      .step     (below_s),
      .cnt      (run_cnt),
      .cnt_next (run_cnt_next)
   );

   assign trip        = active && cfg_rst_en && below_s && (run_cnt_next >= TRIP_AT);
   assign release_now = above_s || !active || !cfg_rst_en;

   lvr_hold_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trip        (trip),
      .release_now (release_now),
      .hold        (lv_reset_req)
   );

   assign low_flag  = below_s;
   assign ext_rst_n = !lv_reset_req;
endmodule

// File: rtl/lvr_filter_ctrl_chk.sv
module lvr_filter_ctrl_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pwr_en,
   input logic             cfg_rst_en,
   input logic             lv_reset_req,
   input logic             ext_rst_n,
   input logic             above_s,
   input logic             below_s,
   input logic             active,
   input logic [CNT_W-1:0] run_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assert_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lv_reset_req |-> !ext_rst_n);

   assert_no_req_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pwr_en |=> !lv_reset_req);

   assert_no_req_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rst_en |=> !lv_reset_req);

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_reset_req && above_s) |=> !lv_reset_req);

   assert_rise_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lv_reset_req) |-> $past(below_s));

   assert_cnt_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == CNT_MAX && below_s && active) |=> run_cnt == CNT_MAX);
endmodule

bind lvr_filter_ctrl lvr_filter_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_pwr_en   (cfg_pwr_en),
   .cfg_rst_en   (cfg_rst_en),
   .lv_reset_req (lv_reset_req),
   .ext_rst_n    (ext_rst_n),
   .above_s      (above_s),
   .below_s      (below_s),
   .active       (active),
   .run_cnt      (run_cnt)
);

// File: tb/test_lvr_filter_ctrl.sv
module test_lvr_filter_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TRIP = 9;
   localparam int SAT  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_pwr_en = 1'b1, cfg_rst_en = 1'b1, cfg_stop_en = 1'b0, stop_mode = 1'b0;
   logic cmp_below_fall = 1'b0, cmp_above_rise = 1'b0;
   logic low_flag, lv_reset_req, ext_rst_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  flag;
      logic  req;
      string tag;
   } exp_t;
   exp_t expq[$];

   // bench reference state
   logic b1 = 0, b2 = 0, a1 = 0, a2 = 0, m_req = 0;
   int   m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvr_filter_ctrl i_lvr_filter_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_pwr_en(cfg_pwr_en), .cfg_rst_en(cfg_rst_en),
      .cfg_stop_en(cfg_stop_en), .stop_mode(stop_mode),
      .cmp_below_fall(cmp_below_fall), .cmp_above_rise(cmp_above_rise),
      .low_flag(low_flag), .lv_reset_req(lv_reset_req), .ext_rst_n(ext_rst_n)
   );

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // driver: apply one cycle of stimulus and push expected post-edge outputs
   task automatic drive(input logic below, input logic above, input logic pwr,
                        input logic ren, input logic sen, input logic stp, input string tag);
      logic act_m;
      int   n_cnt;
      logic n_req;
      exp_t e;
      @(negedge clk);
      cmp_below_fall = below; cmp_above_rise = above;
      cfg_pwr_en = pwr; cfg_rst_en = ren; cfg_stop_en = sen; stop_mode = stp;
      act_m = pwr && (!stp || sen);
      n_cnt = (act_m && b2) ? ((m_cnt >= SAT) ? SAT : m_cnt + 1) : 0;
      if (m_req) n_req = !(a2 || !act_m || !ren);
      else       n_req = act_m && ren && b2 && (n_cnt >= TRIP);
      m_cnt = n_cnt; m_req = n_req;
      b2 = b1; b1 = below; a2 = a1; a1 = above;
      e.flag = b2; e.req = m_req; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic run(input int n, input logic below, input logic above, input logic pwr,
                      input logic ren, input logic sen, input logic stp, input string tag);
      for (int i = 0; i < n; i++) drive(below, above, pwr, ren, sen, stp, tag);
   endtask

   // monitor: compare after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check({e.tag, "/R2"}, low_flag, e.flag, "low_flag");
            check(e.tag, lv_reset_req, e.req, "lv_reset_req");
            check({e.tag, "/R9"}, ext_rst_n, !e.req, "ext_rst_n");
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", low_flag, 1'b0, "flag in reset");
      check("R1", lv_reset_req, 1'b0, "req in reset");
      check("R1", ext_rst_n, 1'b1, "pin in reset");
      rst_n = 1'b1;
      run(3, 0, 0, 1, 1, 0, 0, "R1");
      // R2: flag follows comparator with enables off
      run(3, 1, 0, 0, 0, 0, 1, "R2");
      run(3, 0, 0, 1, 1, 0, 0, "R2");
      // R4: eight-cycle dips split by one high cycle
      run(8, 1, 0, 1, 1, 0, 0, "R4");
      run(1, 0, 0, 1, 1, 0, 0, "R4");
      run(8, 1, 0, 1, 1, 0, 0, "R4");
      run(4, 0, 0, 1, 1, 0, 0, "R4");
      // R3: sustained dip trips on ninth cycle
      run(12, 1, 0, 1, 1, 0, 0, "R3");
      run(3, 0, 0, 1, 1, 0, 0, "R5");
      // R5: single-cycle rise releases
      run(1, 0, 1, 1, 1, 0, 0, "R5");
      run(4, 0, 0, 1, 1, 0, 0, "R5");
      // R6: power off ignores dip; dropping power releases
      run(15, 1, 0, 0, 1, 0, 0, "R6");
      run(12, 1, 0, 1, 1, 0, 0, "R6");
      run(3, 1, 0, 0, 1, 0, 0, "R6");
      run(4, 0, 0, 1, 1, 0, 0, "R6");
      // R7 and R10: reset disabled through long dip, then enabled
      run(12, 1, 0, 1, 1, 0, 0, "R7");
      run(3, 1, 0, 1, 0, 0, 0, "R7");
      run(30, 1, 0, 1, 0, 0, 0, "R10");
      run(3, 1, 0, 1, 1, 0, 0, "R10");
      run(2, 0, 0, 1, 1, 0, 0, "R10");
      run(1, 0, 1, 1, 1, 0, 0, "R5");
      run(4, 0, 0, 1, 1, 0, 0, "R5");
      // R8: stop mode without and with stop enable
      run(15, 1, 0, 1, 1, 0, 1, "R8");
      run(3, 0, 0, 1, 1, 0, 1, "R8");
      run(12, 1, 0, 1, 1, 1, 1, "R8");
      run(3, 0, 0, 1, 1, 1, 1, "R8");
      run(1, 0, 1, 1, 1, 1, 1, "R8");
      run(4, 0, 0, 1, 1, 0, 0, "R8");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule